// File: doc/BRIEF.md
# Wide-Port Aligned RAM

A single-clock RAM that stores narrow words but is reached through one write port and one read port, each a power-of-two multiple wider than the stored word. One wide access covers an aligned group of consecutive words. The group is picked by the upper address bits, and the low address bits must be zero. Inside the block, each wide port is split into per-word lanes. Every lane shares the port's controls and forms its word address from the group address, with its own lane index in the low bits. Lane 0 sits on the lowest bits of the wide data bus.

The write port has one enable per data bit, so any subset of bits in the group can be updated. The read port is registered on the rising clock edge. A read that hits words being written in the same cycle returns their contents from before the write. An access whose low address bits are not zero is treated as an error: a flag is raised, and neither a write nor a read update takes place.

Top module: `wide_ram`

## Requirements
- R1: While rst_ni is low and after its release, rd_data_o, wr_err_o and rd_err_o are zero and every stored word reads as zero.
- R2: A write at an address whose low MULT_LOG2 bits are zero stores the bits `[l*WORD_W +: WORD_W]` of wr_data_i into the word at that address plus l, for each l from 0 to MULT-1.
- R3: A data bit of a stored word changes only when its enable bit (the same bit position in wr_bit_en_i) is 1. Bits whose enable is 0 keep their value.
- R4: With rd_en_i high at an aligned address, on the next rising edge rd_data_o takes the words at that address plus l, placed in bits `[l*WORD_W +: WORD_W]`.
- R5: A read and a write to the same group in the same cycle make rd_data_o show the contents from before that write.
- R6: A write with any enable bit set and non-zero low address bits changes no stored word and sets wr_err_o on the next edge. In every other case wr_err_o is 0 after the next edge.
- R7: A read with non-zero low address bits leaves rd_data_o unchanged and sets rd_err_o on the next edge.
- R8: With rd_en_i low, rd_data_o holds its value and rd_err_o is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_bit_en_i | input | WORD_W*MULT | Per-bit write enables |
| wr_addr_i | input | ABITS | Word address of write group |
| wr_data_i | input | WORD_W*MULT | Write data, lane 0 lowest |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ABITS | Word address of read group |
| rd_data_o | output | WORD_W*MULT | Registered read data, lane 0 lowest |
| wr_err_o | output | 1 | Previous write was misaligned |
| rd_err_o | output | 1 | Previous read was misaligned |

## Verification
The bench uses the default parameters: 8-bit words, 16 words, and a multiple of 4. With these values there are four groups, so every one of the three non-zero low-address patterns can be tried on both ports. Every lane position is written and read back, and the whole array can be filled and drained many times within a short run. Directed phases cover partial bit enables, reads in the same cycle as writes to the same group, and misaligned accesses, both with and without enables. A long random phase then mixes all of these.

// File: rtl/wram_pkg.sv
package wram_pkg;
  function automatic int unsigned lane_count(input int unsigned mult_log2);
    return 32'd1 << mult_log2;
  endfunction
endpackage

// File: rtl/wram_lane_addr.sv
module wram_lane_addr
  import wram_pkg::*;
#(
  parameter int unsigned ABITS     = 4,
  parameter int unsigned MULT_LOG2 = 2,
  localparam int unsigned MULT     = lane_count(MULT_LOG2)
) (
  input  logic [ABITS-1:0]            addr_i,
  output logic [MULT-1:0][ABITS-1:0]  lane_addr_o,
  output logic                        misalign_o
);
  for (genvar l = 0; l < MULT; l++) begin : g_lane
    if (MULT_LOG2 == 0) begin : g_narrow
      assign lane_addr_o[l] = addr_i;
    end else begin : g_wide
      assign lane_addr_o[l] = {addr_i[ABITS-1:MULT_LOG2], MULT_LOG2'(l)};
    end
  end

  if (MULT_LOG2 == 0) begin : g_no_chk
    assign misalign_o = 1'b0;
  end else begin : g_chk
    assign misalign_o = |addr_i[MULT_LOG2-1:0];
  end
endmodule

// File: rtl/wram_array.sv
module wram_array
  import wram_pkg::*;
#(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned ABITS     = 4,
  parameter int unsigned MULT_LOG2 = 2,
  localparam int unsigned MULT     = lane_count(MULT_LOG2)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [MULT-1:0][WORD_W-1:0]     we_i,
  input  logic [MULT-1:0][ABITS-1:0]      wa_i,
  input  logic [MULT-1:0][WORD_W-1:0]     wd_i,
  input  logic [MULT-1:0][ABITS-1:0]      ra_i,
  output logic [MULT-1:0][WORD_W-1:0]     rd_o
);
  logic [DEPTH-1:0][WORD_W-1:0] mem_w;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam int unsigned L = w % MULT;
    logic [WORD_W-1:0] q;
    logic              hit;
    assign hit = (wa_i[L] == ABITS'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= (q & ~we_i[L]) | (wd_i[L] & we_i[L]);
    end
    assign mem_w[w] = q;
  end

  // read sees pre-edge contents: old data on collision
  for (genvar l = 0; l < MULT; l++) begin : g_rd
    assign rd_o[l] = mem_w[ra_i[l]];

    if (MULT_LOG2 > 0) begin : g_lane_chk
      p_lane_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|we_i[l]) |-> (wa_i[l][MULT_LOG2-1:0] == MULT_LOG2'(l)))
        else $error("write lane %0d off its slot", l);
      p_lane_group_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|we_i[l]) |-> (wa_i[l][ABITS-1:MULT_LOG2] == wa_i[0][ABITS-1:MULT_LOG2]))
        else $error("write lane %0d left its group", l);
    end
  end
endmodule

// File: rtl/wide_ram.sv
module wide_ram
  import wram_pkg::*;
#(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned MULT_LOG2 = 2,
  localparam int unsigned MULT     = lane_count(MULT_LOG2),
  localparam int unsigned WIDE_W   = WORD_W * MULT,
  localparam int unsigned ABITS    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDE_W-1:0] wr_bit_en_i,
  input  logic [ABITS-1:0]  wr_addr_i,
  input  logic [WIDE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ABITS-1:0]  rd_addr_i,
  output logic [WIDE_W-1:0] rd_data_o,
  output logic              wr_err_o,
  output logic              rd_err_o
);
  logic [MULT-1:0][ABITS-1:0]  wr_lane_addr, rd_lane_addr;
  logic [MULT-1:0][WORD_W-1:0] wr_lane_en, wr_lane_data, rd_lane_word;
  logic                        wr_misalign, rd_misalign;
  logic [WIDE_W-1:0]           rd_q;
  logic                        wr_err_q, rd_err_q;

  wram_lane_addr #(.ABITS(ABITS), .MULT_LOG2(MULT_LOG2)) u_wr_addr (
    .addr_i(wr_addr_i), .lane_addr_o(wr_lane_addr), .misalign_o(wr_misalign));

  wram_lane_addr #(.ABITS(ABITS), .MULT_LOG2(MULT_LOG2)) u_rd_addr (
    .addr_i(rd_addr_i), .lane_addr_o(rd_lane_addr), .misalign_o(rd_misalign));

  // lane 0 occupies the low bits of the wide bus
  assign wr_lane_en   = wr_misalign ? '0 : wr_bit_en_i;
  assign wr_lane_data = wr_data_i;

  wram_array #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ABITS(ABITS), .MULT_LOG2(MULT_LOG2)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_lane_en), .wa_i(wr_lane_addr), .wd_i(wr_lane_data),
    .ra_i(rd_lane_addr), .rd_o(rd_lane_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= '0;
      rd_err_q <= 1'b0;
      wr_err_q <= 1'b0;
    end else begin
      if (rd_en_i && !rd_misalign) rd_q <= rd_lane_word;
      rd_err_q <= rd_en_i && rd_misalign;
      wr_err_q <= wr_misalign && (|wr_bit_en_i);
    end
  end

  assign rd_data_o = rd_q;
  assign wr_err_o  = wr_err_q;
  assign rd_err_o  = rd_err_q;

  p_rd_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> ($stable(rd_data_o) && !rd_err_o))
    else $error("read data moved while idle");

  if (MULT_LOG2 > 0) begin : g_port_chk
    p_rd_misalign_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && (|rd_addr_i[MULT_LOG2-1:0])) |=> ($stable(rd_data_o) && rd_err_o))
      else $error("misaligned read updated data or missed flag");
    p_wr_misalign_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|wr_bit_en_i) && (|wr_addr_i[MULT_LOG2-1:0])) |=> wr_err_o)
      else $error("misaligned write not flagged");
    p_wr_aligned_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_addr_i[MULT_LOG2-1:0] == '0) |=> !wr_err_o)
      else $error("aligned write flagged");
  end
endmodule

// File: tb/wide_ram_test.sv
`timescale 1ns/1ps
module wide_ram_test;
  localparam int W      = 8;
  localparam int DEPTH  = 16;
  localparam int ML2    = 2;
  localparam int MULT   = 1 << ML2;
  localparam int WIDE   = W * MULT;
  localparam int AB     = $clog2(DEPTH);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [WIDE-1:0] wr_bit_en = '0, wr_data = '0;
  logic [AB-1:0]   wr_addr = '0, rd_addr = '0;
  logic            rd_en = 1'b0;
  logic [WIDE-1:0] rd_data;
  logic            wr_err, rd_err;

  wide_ram #(.WORD_W(W), .DEPTH(DEPTH), .MULT_LOG2(ML2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_bit_en_i(wr_bit_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .wr_err_o(wr_err), .rd_err_o(rd_err));

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [W-1:0]    ref_mem [DEPTH];
  logic [WIDE-1:0] exp_rd = '0;
  logic            exp_werr = 1'b0, exp_rerr = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [WIDE-1:0] act, input logic [WIDE-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // apply one cycle of stimulus, advance model, compare after the edge
  task automatic step(input string req, input logic [WIDE-1:0] ben, input logic [AB-1:0] wa,
                      input logic [WIDE-1:0] wd, input logic re, input logic [AB-1:0] ra);
    wr_bit_en = ben; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    exp_rerr = re && (ra % MULT != 0);
    if (re && (ra % MULT == 0))
      for (int l = 0; l < MULT; l++) exp_rd[l*W +: W] = ref_mem[ra + l];
    exp_werr = (wa % MULT != 0) && (ben != '0);
    if (wa % MULT == 0)
      for (int l = 0; l < MULT; l++)
        ref_mem[wa + l] = (ref_mem[wa + l] & ~ben[l*W +: W]) | (wd[l*W +: W] & ben[l*W +: W]);
    @(posedge clk);
    @(negedge clk);
    chk(req, "rd_data_o", rd_data, exp_rd);
    chk(req, "wr_err_o", WIDE'(wr_err), WIDE'(exp_werr));
    chk(req, "rd_err_o", WIDE'(rd_err), WIDE'(exp_rerr));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rd_data_o in reset", rd_data, '0);
    chk("R1", "wr_err_o in reset", WIDE'(wr_err), '0);
    chk("R1", "rd_err_o in reset", WIDE'(rd_err), '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int g = 0; g < DEPTH; g += MULT) step("R1", '0, '0, '0, 1'b1, AB'(g));

    // R2: full writes, distinct per lane, then read back
    for (int g = 0; g < DEPTH; g += MULT)
      step("R2", '1, AB'(g), WIDE'({8'(g+4), 8'(g+3), 8'(g+2), 8'(g+1)}) ^ 32'hA5C3_0F50, 1'b0, '0);
    for (int g = 0; g < DEPTH; g += MULT) step("R2", '0, '0, '0, 1'b1, AB'(g));

    // R3: partial bit enables
    step("R3", 32'h0000_00F0, AB'(0), 32'hFFFF_FFFF, 1'b0, '0);
    step("R3", 32'hFF00_0001, AB'(4), 32'h0000_0000, 1'b0, '0);
    step("R3", 32'h00FF_FF00, AB'(8), 32'h1234_5678, 1'b1, AB'(0));
    for (int g = 0; g < DEPTH; g += MULT) step("R3", '0, '0, '0, 1'b1, AB'(g));

    // R5: read and write to the same group in the same cycle
    step("R5", '1, AB'(12), 32'hDEAD_BEEF, 1'b1, AB'(12));
    step("R5", 32'h0F0F_0F0F, AB'(12), 32'h0000_0000, 1'b1, AB'(12));
    step("R5", '0, '0, '0, 1'b1, AB'(12));

    // R6: misaligned writes, with and without enables
    for (int o = 1; o < MULT; o++) step("R6", '1, AB'(4 + o), 32'h5555_5555, 1'b0, '0);
    step("R6", '0, AB'(9), 32'hFFFF_FFFF, 1'b0, '0);
    for (int g = 0; g < DEPTH; g += MULT) step("R6", '0, '0, '0, 1'b1, AB'(g));

    // R7: misaligned reads
    for (int o = 1; o < MULT; o++) step("R7", '0, '0, '0, 1'b1, AB'(8 + o));

    // R8: idle reads
    step("R8", '1, AB'(0), 32'h0BAD_F00D, 1'b0, '0);
    step("R8", '0, '0, '0, 1'b0, '0);

    // R4: random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AB-1:0] wa, ra;
      wa = AB'($urandom);
      ra = AB'($urandom);
      if ($urandom_range(3) != 0) wa = wa & ~AB'(MULT - 1);
      if ($urandom_range(3) != 0) ra = ra & ~AB'(MULT - 1);
      step("R4", ($urandom_range(1) == 1) ? WIDE'($urandom) : '0, wa, WIDE'($urandom),
           1'($urandom_range(3) != 0), ra);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule